// File: doc/BRIEF.md
# Tick Counter with Periodic Alarm Interrupt

This block is a memory-mapped system timer. A prescaler divides the core clock by `DIV_RATIO` (ten by default, which turns a 160 MHz core clock into a 16 MHz timebase). Each prescaler tick advances a 64-bit free-running counter. A periodic comparator, alarm 0, raises its raw interrupt flag every `ALARM_TICKS` ticks. The default of 16,000 ticks gives a 1 ms period at the default clocks. Software sees the alarm through four separate views: a 32-bit enable word, a sticky raw-flag word, a write-one-to-acknowledge word and a masked pending word. A single interrupt line is the OR of the pending bits.

Software cannot read the 64-bit counter directly. It writes a capture-request bit, which copies the counter into two 32-bit readout words at once. A valid flag goes low on the request and comes back high one cycle later, when the words are ready to read.

The register bus addresses bytes and has no handshake. A write takes one byte (`bus_we`, `bus_addr`, `bus_wdata`) and completes on the next clock edge. `bus_rdata` returns, combinationally, the byte at `bus_addr` of the addressed 32-bit word. No data stream enters or leaves the block, so there is no valid/ready pair and no back-pressure. Reads have no side effects.

Top module: `tick_alarm_timer`

## Requirements
- R1: The counter advances by exactly one on every `DIV_RATIO`-th clock edge after reset is released. After N such edges it holds floor(N / DIV_RATIO).
- R2: Bit 0 of the raw word (offset 0x08) becomes 1 on the clock edge that completes every `ALARM_TICKS`-th tick (edge N with N a multiple of DIV_RATIO*ALARM_TICKS). It sets even when the enable bit is 0 and stays set until acknowledged. Raw bits 1 and 2 (alarms 1 and 2) always read 0, and all other raw bits read 0.
- R3: The pending word (offset 0x10) reads as the raw bits [2:0] ANDed with enable bits [2:0]. `irq_o` is 1 exactly when any pending bit is 1.
- R4: A byte write to offset 0x0C clears each raw bit [2:0] whose matching data bit is 1. Data bits equal to 0, and writes to offsets 0x0D to 0x0F, leave the raw bits unchanged. Offset 0x0C reads as 0.
- R5: When an acknowledge write and an alarm fall on the same clock edge, raw bit 0 is 1 after that edge.
- R6: A byte write to offset 0x17 with data bit 6 set (bit 30 of the control word at 0x14) copies the counter value held before that edge into the readout words: low half at 0x54, high half at 0x58. Any other write to the control word leaves the readout words unchanged.
- R7: Bit 29 of the control word is the capture-valid flag. It reads 0 after reset and 0 in the cycle after a capture request. It reads 1 from the following cycle onward when no new request arrives.
- R8: A byte write to offsets 0x04 to 0x07 replaces only enable bits [8k+7:8k], where k is the byte offset within the word. All 32 enable bits read back.
- R9: Reset sets the enable, raw, pending, control and readout words to 0 and drives `irq_o` to 0.
- R10: Writes to the raw and pending words are ignored. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Byte write strobe, taken on the rising clock edge |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte at `bus_addr` (combinational) |
| irq_o | output | 1 | Interrupt: OR of the pending bits |

## Verification
The hardest case to reach from the ports is an acknowledge write that lands on the exact edge where the alarm fires. That edge exists only once per DIV_RATIO*ALARM_TICKS cycles. The bench builds the timer with a divider of 3 and a period of 4 ticks, counts clock edges since reset itself, and issues the acknowledge one cycle before a computed multiple of 12. The same edge count lets it sweep capture requests across every prescaler phase and predict each captured value by integer division.

// File: rtl/tat_pkg.sv
package tat_pkg;

  // Alarm slots visible in the status words (alarm 0 is the only live one)
  localparam int NUM_TARGETS = 3;

  // Word indices (byte address bits [7:2])
  localparam logic [5:0] W_ALM_EN   = 6'd1;   // 0x04
  localparam logic [5:0] W_ALM_RAW  = 6'd2;   // 0x08
  localparam logic [5:0] W_ALM_ACK  = 6'd3;   // 0x0C
  localparam logic [5:0] W_ALM_PEND = 6'd4;   // 0x10
  localparam logic [5:0] W_CAP_CTRL = 6'd5;   // 0x14
  localparam logic [5:0] W_CAP_LO   = 6'd21;  // 0x54
  localparam logic [5:0] W_CAP_HI   = 6'd22;  // 0x58

  // Control word fields
  localparam int CAP_REQ_BIT   = 30;
  localparam int CAP_VALID_BIT = 29;

  typedef struct packed {
    logic       we;
    logic [5:0] word;
    logic [1:0] lane;
    logic [7:0] data;
  } bus_wr_t;

endpackage

// File: rtl/tat_prescaler.sv
module tat_prescaler #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + PW'(1);
  end

  assign tick_o = (phase == LAST);

  // R1: after a tick the phase restarts, so ticks are DIV edges apart
  a_r1_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (phase == '0));

endmodule

// File: rtl/tat_alarm_counter.sv
module tat_alarm_counter #(
  parameter int CNT_W  = 64,
  parameter int PERIOD = 16000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             fire_o
);
  localparam int AW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [AW-1:0] SLOT_LAST = AW'(PERIOD - 1);

  logic [AW-1:0] slot;

  assign fire_o = tick_i && (slot == SLOT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
      slot    <= '0;
    end else if (tick_i) begin
      count_o <= count_o + CNT_W'(1);
      slot    <= fire_o ? '0 : slot + AW'(1);
    end
  end

  // R1: the counter moves only on a tick, and by one
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (count_o == $past(count_o) + CNT_W'(1)));
  a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(count_o));
  // R2: an alarm only ever comes on a tick
  a_r2_fire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> tick_i);

endmodule

// File: rtl/tat_irq_regs.sv
module tat_irq_regs
  import tat_pkg::*;
#(
  parameter int NT = NUM_TARGETS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_wr_t       wr_i,
  input  logic [NT-1:0] fire_i,
  output logic [31:0]   ena_o,
  output logic [NT-1:0] raw_o,
  output logic [NT-1:0] pend_o,
  output logic          irq_o
);
  logic          ena_wr;
  logic [NT-1:0] ack;

  assign ena_wr = wr_i.we && (wr_i.word == W_ALM_EN);
  assign ack    = (wr_i.we && (wr_i.word == W_ALM_ACK) && (wr_i.lane == 2'd0))
                ? wr_i.data[NT-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ena_o <= '0;
    else if (ena_wr) ena_o[{wr_i.lane, 3'b000} +: 8] <= wr_i.data;
  end

  for (genvar t = 0; t < NT; t++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_o[t] <= 1'b0;
      else        raw_o[t] <= fire_i[t] | (raw_o[t] & ~ack[t]);
    end
  end

  assign pend_o = raw_o & ena_o[NT-1:0];
  assign irq_o  = |pend_o;

  // R5: a new alarm beats a same-edge acknowledge
  a_r5_alarm_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i[0] |=> raw_o[0]);
  // R4: acknowledge without a new alarm clears the flag
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[0] && !fire_i[0]) |=> !raw_o[0]);
  // R2: raw flag is sticky until acknowledged
  a_r2_raw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_o[0] && !ack[0]) |=> raw_o[0]);
  // R8: a lane-0 enable write leaves the upper lanes alone
  a_r8_lane_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_wr && wr_i.lane == 2'd0) |=> (ena_o[31:8] == $past(ena_o[31:8])));

endmodule

// File: rtl/tat_snapshot.sv
module tat_snapshot #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [63:0]      snap_o,
  output logic             valid_o
);
  logic fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_o  <= '0;
      valid_o <= 1'b0;
      fresh   <= 1'b0;
    end else if (req_i) begin
      snap_o  <= 64'(count_i);
      valid_o <= 1'b0;
      fresh   <= 1'b1;
    end else if (fresh) begin
      valid_o <= 1'b1;
      fresh   <= 1'b0;
    end
  end

  // R7: request drops the flag, which returns one cycle later
  a_r7_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> !valid_o);
  a_r7_valid_returns: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(valid_o) && !req_i) |=> valid_o);
  // R6: the readout holds the counter seen at the request edge
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> (snap_o == 64'($past(count_i))));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> $stable(snap_o));

endmodule

// File: rtl/tick_alarm_timer.sv
module tick_alarm_timer
  import tat_pkg::*;
#(
  parameter int DIV_RATIO   = 10,
  parameter int ALARM_TICKS = 16000,
  parameter int CNT_W       = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_o
);
  localparam int NT = NUM_TARGETS;
  localparam logic [1:0] REQ_LANE = 2'(CAP_REQ_BIT / 8);
  localparam int         REQ_POS  = CAP_REQ_BIT % 8;

  bus_wr_t          wr;
  logic             tick;
  logic             fire0;
  logic [CNT_W-1:0] count;
  logic [31:0]      ena;
  logic [NT-1:0]    raw;
  logic [NT-1:0]    pend;
  logic [63:0]      snap;
  logic             cap_valid;
  logic             cap_req;
  logic [31:0]      rword;

  always_comb begin
    wr.we   = bus_we;
    wr.word = bus_addr[7:2];
    wr.lane = bus_addr[1:0];
    wr.data = bus_wdata;
  end

  assign cap_req = wr.we && (wr.word == W_CAP_CTRL) && (wr.lane == REQ_LANE)
                && wr.data[REQ_POS];

  tat_prescaler #(.DIV(DIV_RATIO)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  tat_alarm_counter #(.CNT_W(CNT_W), .PERIOD(ALARM_TICKS)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .count_o (count),
    .fire_o  (fire0)
  );

  tat_irq_regs #(.NT(NT)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (wr),
    .fire_i ({{(NT-1){1'b0}}, fire0}),
    .ena_o  (ena),
    .raw_o  (raw),
    .pend_o (pend),
    .irq_o  (irq_o)
  );

  tat_snapshot #(.CNT_W(CNT_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (cap_req),
    .count_i (count),
    .snap_o  (snap),
    .valid_o (cap_valid)
  );

  always_comb begin
    rword = '0;
    case (bus_addr[7:2])
      W_ALM_EN:   rword = ena;
      W_ALM_RAW:  rword = 32'(raw);
      W_ALM_PEND: rword = 32'(pend);
      W_CAP_CTRL: rword[CAP_VALID_BIT] = cap_valid;
      W_CAP_LO:   rword = snap[31:0];
      W_CAP_HI:   rword = snap[63:32];
      default:    rword = '0;
    endcase
  end

  assign bus_rdata = rword[{bus_addr[1:0], 3'b000} +: 8];

  // R9: nothing is pending while nothing is enabled
  a_r9_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (ena[NT-1:0] == '0) |-> !irq_o);

endmodule

// File: tb/tick_alarm_timer_test.sv
`timescale 1ns/100ps
module tick_alarm_timer_test;
  localparam int DIV   = 3;
  localparam int TICKS = 4;
  localparam int PER   = DIV * TICKS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  tick_alarm_timer #(.DIV_RATIO(DIV), .ALARM_TICKS(TICKS), .CNT_W(64)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr8(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd32(logic [7:0] a, output logic [31:0] v);
    for (int l = 0; l < 4; l++) begin
      addr = a + 8'(l);
      #0.1;
      v[8*l +: 8] = rdata;
    end
  endtask

  // acknowledge all flags on an edge that carries no alarm
  task automatic sync_clear();
    while (cyc % PER != 1) @(negedge clk);
    wr8(8'h0C, 8'h07);
  endtask

  task automatic wait_alarm();
    @(negedge clk);
    while (cyc % PER != 0) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] old_lo;
    bit seen;
    int n;

    // R9: reset state, read while reset is held
    repeat (2) @(negedge clk);
    rd32(8'h04, v); chk("R9 enable", 64'(v), 64'h0);
    rd32(8'h08, v); chk("R9 raw", 64'(v), 64'h0);
    rd32(8'h10, v); chk("R9 pending", 64'(v), 64'h0);
    rd32(8'h14, v); chk("R9 R7 control/valid", 64'(v), 64'h0);
    rd32(8'h54, v); chk("R9 readout lo", 64'(v), 64'h0);
    rd32(8'h58, v); chk("R9 readout hi", 64'(v), 64'h0);
    chk("R9 irq", 64'(irq), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: byte-lane merge of the enable word
    wr8(8'h07, 8'hC3); rd32(8'h04, v); chk("R8 lane3", 64'(v), 64'hC300_0000);
    wr8(8'h05, 8'h5A); rd32(8'h04, v); chk("R8 lane1", 64'(v), 64'hC300_5A00);
    wr8(8'h06, 8'hFF); rd32(8'h04, v); chk("R8 lane2", 64'(v), 64'hC3FF_5A00);
    wr8(8'h04, 8'h00); rd32(8'h04, v); chk("R8 lane0", 64'(v), 64'hC3FF_5A00);
    for (int k = 4; k < 8; k++) wr8(8'(k), 8'h00);
    rd32(8'h04, v); chk("R8 cleared", 64'(v), 64'h0);

    // R10: read-only words ignore writes, unmapped reads 0
    sync_clear();
    wr8(8'h08, 8'hFF); rd32(8'h08, v); chk("R10 raw write ignored", 64'(v), 64'h0);
    wr8(8'h10, 8'hFF); rd32(8'h10, v); chk("R10 pending write ignored", 64'(v), 64'h0);
    rd32(8'h20, v); chk("R10 unmapped", 64'(v), 64'h0);
    @(negedge clk);
    rd32(8'h0C, v); chk("R4 ack word reads 0", 64'(v), 64'h0);

    // R2: alarm timing with enable 0, swept across whole periods
    for (int rep = 0; rep < 3; rep++) begin
      sync_clear();
      seen = 0;
      for (int i = 0; i < PER + 2; i++) begin
        @(negedge clk);
        if (cyc % PER == 0) seen = 1;
        rd32(8'h08, v);
        chk("R2 raw timing", 64'(v), 64'(seen));
        chk("R3 irq masked off", 64'(irq), 64'h0);
      end
    end

    // R3: pending word and irq over all enable patterns of the three slots
    for (int e = 0; e < 8; e++) begin
      wr8(8'h04, 8'(e));
      sync_clear();
      rd32(8'h10, v); chk("R3 pending before alarm", 64'(v), 64'h0);
      chk("R3 irq before alarm", 64'(irq), 64'h0);
      wait_alarm();
      rd32(8'h08, v); chk("R2 raw after alarm", 64'(v), 64'h1);
      rd32(8'h10, v); chk("R3 pending", 64'(v), 64'(e & 1));
      chk("R3 irq", 64'(irq), 64'(e & 1));
    end

    // R4: zero bits and other lanes do not clear
    wr8(8'h0C, 8'h00); rd32(8'h08, v); chk("R4 zero ack", 64'(v), 64'h1);
    wr8(8'h0D, 8'hFF); rd32(8'h08, v); chk("R4 lane1 ack", 64'(v), 64'h1);
    wr8(8'h0C, 8'h06); rd32(8'h08, v); chk("R4 other bits ack", 64'(v), 64'h1);
    while (cyc % PER == PER - 1) @(negedge clk);
    wr8(8'h0C, 8'h01); rd32(8'h08, v); chk("R4 ack clears", 64'(v), 64'h0);
    chk("R4 irq drops", 64'(irq), 64'h0);

    // R5: acknowledge on the very alarm edge
    for (int rep = 0; rep < 2; rep++) begin
      while (cyc % PER != PER - 1) @(negedge clk);
      wr8(8'h0C, 8'h01);
      rd32(8'h08, v); chk("R5 alarm wins", 64'(v), 64'h1);
      chk("R5 irq", 64'(irq), 64'h1);
      wr8(8'h0C, 8'h01);
      rd32(8'h08, v); chk("R5 later ack clears", 64'(v), 64'h0);
    end
    wr8(8'h04, 8'h00);

    // R6 R7 R1: capture swept over all prescaler phases
    for (int i = 0; i < 2 * PER + DIV; i++) begin
      if (i % 4 == 0) @(negedge clk);
      wr8(8'h17, 8'h40);
      n = cyc;
      rd32(8'h14, v); chk("R7 valid low after request", 64'(v), 64'h0);
      @(negedge clk);
      rd32(8'h14, v); chk("R7 valid back", 64'(v), 64'h2000_0000);
      rd32(8'h54, v); chk("R1 R6 readout lo", 64'(v), 64'((n - 1) / DIV));
      rd32(8'h58, v); chk("R6 readout hi", 64'(v), 64'h0);
    end

    // R6: other control writes do not capture
    rd32(8'h54, old_lo);
    repeat (DIV + 1) @(negedge clk);
    wr8(8'h17, 8'h20);
    rd32(8'h14, v); chk("R6 no capture valid", 64'(v), 64'h2000_0000);
    rd32(8'h54, v); chk("R6 no capture lo", 64'(v), 64'(old_lo));
    wr8(8'h14, 8'h40);
    rd32(8'h54, v); chk("R6 wrong lane no capture", 64'(v), 64'(old_lo));

    // R1: capture after a long idle stretch
    repeat (1000) @(negedge clk);
    wr8(8'h17, 8'h40);
    n = cyc;
    @(negedge clk);
    rd32(8'h54, v); chk("R1 long run count", 64'(v), 64'((n - 1) / DIV));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule